// File: doc/BRIEF.md
# Fault Input Glitch Filter

This block conditions one fault input of a PWM module before the fault logic acts on it. The raw pin first passes through a two-stage synchronizer. The block then samples it every P clock cycles. A level change reaches the filtered output only after N samples in a row show the new level. When P is zero, the filter is bypassed and the filtered level follows the synchronized pin on every cycle.

A polarity bit selects whether a low or a high filtered level counts as a fault. While the filtered level is at the fault level, a status output is high. The same condition also sets a sticky flag, which software clears by writing a one to it. If the interrupt enable bit is set, the flag drives an interrupt request.

Software uses a single-cycle write strobe with an address. Read data is combinational on the address. All pins are plain control and status signals, so no flow control is involved. Output masking of the PWM pins is done elsewhere.

Top module: `fault_glitch_filter`

## Requirements
- R1: The raw input passes through two synchronizer flops. In bypass, a change on `fault_in` that is set up before a rising edge appears on `fault_active` after the third rising edge, and not before.
- R2: The sample period field P is configuration bits [3:0], at address 0. When P ≥ 1, the synchronized input is sampled once every P cycles. A write to address 0 restarts the sampling phase.
- R3: The count field N is configuration bits [6:4]. A level change is accepted after N consecutive samples agree with the new level. A sample that shows the current filtered level restarts the count. As a result, a pulse held for N·P cycles is always accepted, and a pulse held for (N−1)·P cycles never is.
- R4: A count field of 0 behaves exactly like a count of 1.
- R5: A sample period of 0 bypasses the filter. The filtered level then follows the synchronized input every cycle.
- R6: Polarity is configuration bit 7. When it is 0, a low filtered level is the fault. When it is 1, a high filtered level is the fault.
- R7: `fault_active` is high exactly while the filtered level is at the fault level. The filtered level resets to the non-fault level, so after reset `fault_active`, `irq` and both registers read 0.
- R8: The fault flag is status bit 1 at address 1. It is set while the fault level is present and stays set until a write to address 1 has bit 1 at one.
- R9: If a fault level and a clearing write occur in the same cycle, the flag stays set.
- R10: Interrupt enable is configuration bit 8. `irq` is high when both the flag and the enable are high. It drops only when the flag is cleared, when the enable is written to 0, or on reset.
- R11: Address 0 reads back the configuration word. Address 1 reads `fault_active` in bit 0 and the flag in bit 1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | 1 | Raw fault pin, asynchronous |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 1 | Register select: 0 configuration, 1 status |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data for `reg_addr` |
| fault_active | output | 1 | Filtered fault level is present |
| irq | output | 1 | Interrupt request |

## Verification
Each kind of wrong internal state shows up at the ports in a different way:
- A stuck or mis-phased prescaler moves the pulse width at which the flag sets, so a sweep that brackets the threshold at exactly N·P and (N−1)·P cycles catches it within one pulse.
- A count register that is not restarted lets a short pulse after an earlier partial run get through, and this appears on the flag about forty cycles after the pulse.
- A synchronizer of the wrong depth shifts the bypass edge on `fault_active` by one cycle.
- Errors in the flag clear priority or the interrupt release rule show on `irq` or on the status read in the cycle right after the write.

// File: rtl/ffilt_pkg.sv
package ffilt_pkg;
  typedef enum logic [0:0] {
    REG_CFG  = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;

  localparam int STAT_PIN_BIT  = 0;
  localparam int STAT_FLAG_BIT = 1;
endpackage

// File: rtl/ffilt_sync.sv
module ffilt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ffilt_sampler.sv
module ffilt_sampler #(
  parameter int   PER_W   = 4,
  parameter int   CNT_W   = 3,
  parameter logic RST_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [CNT_W-1:0] need_i,
  input  logic             din_i,
  output logic             filt_o
);
  logic [PER_W-1:0] pcnt_q;
  logic [CNT_W-1:0] agree_q;
  logic [CNT_W:0]   need_eff;
  logic [CNT_W:0]   agree_next;
  logic             bypass;
  logic             tick;

  assign bypass     = (period_i == '0);
  assign tick       = !bypass && (pcnt_q == period_i - 1'b1);
  assign need_eff   = (need_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, need_i};
  assign agree_next = {1'b0, agree_q} + 1'b1;

  // prescaler: one tick every period_i cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pcnt_q <= '0;
    else if (restart_i || bypass || tick) pcnt_q <= '0;
    else                                pcnt_q <= pcnt_q + 1'b1;
  end

  // consecutive-agreement counter and filtered level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_o  <= RST_LVL;
      agree_q <= '0;
    end else if (bypass) begin
      filt_o  <= din_i;
      agree_q <= '0;
    end else if (restart_i) begin
      agree_q <= '0;
    end else if (tick) begin
      if (din_i == filt_o) begin
        agree_q <= '0;
      end else if (agree_next >= need_eff) begin
        filt_o  <= din_i;
        agree_q <= '0;
      end else begin
        agree_q <= agree_next[CNT_W-1:0];
      end
    end
  end

  // R5
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (filt_o == $past(din_i)));

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !tick) |=> $stable(filt_o));

  // R3
  change_toward_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_o) |-> (filt_o == $past(din_i)));
endmodule

// File: rtl/ffilt_flag.sv
module ffilt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic status_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_o <= 1'b0;
    else if (status_i) flag_o <= 1'b1;
    else if (clr_i)    flag_o <= 1'b0;
  end

  assign irq_o = flag_o && ie_i;

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_i |=> flag_o);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(status_i));

  // R10
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> ($past(clr_i) || !ie_i));
endmodule

// File: rtl/fault_glitch_filter.sv
module fault_glitch_filter #(
  parameter int PER_W = 4,
  parameter int CNT_W = 3,
  localparam int PER_LSB = 0,
  localparam int CNT_LSB = PER_LSB + PER_W,
  localparam int POL_BIT = CNT_LSB + CNT_W,
  localparam int IE_BIT  = POL_BIT + 1,
  localparam int REG_W   = IE_BIT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_in,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             fault_active,
  output logic             irq
);
  import ffilt_pkg::*;

  logic [PER_W-1:0] period_q;
  logic [CNT_W-1:0] need_q;
  logic             pol_q;
  logic             ie_q;
  logic             cfg_wr;
  logic             flag_clr;
  logic             sync_lvl;
  logic             filt_lvl;
  logic             flag;

  assign cfg_wr   = reg_wr && (reg_sel_e'(reg_addr) == REG_CFG);
  assign flag_clr = reg_wr && (reg_sel_e'(reg_addr) == REG_STAT)
                    && reg_wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      need_q   <= '0;
      pol_q    <= 1'b0;
      ie_q     <= 1'b0;
    end else if (cfg_wr) begin
      period_q <= reg_wdata[PER_LSB +: PER_W];
      need_q   <= reg_wdata[CNT_LSB +: CNT_W];
      pol_q    <= reg_wdata[POL_BIT];
      ie_q     <= reg_wdata[IE_BIT];
    end
  end

  ffilt_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (fault_in),
    .q_o   (sync_lvl)
  );

  ffilt_sampler #(.PER_W(PER_W), .CNT_W(CNT_W), .RST_LVL(1'b1)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (cfg_wr),
    .period_i  (period_q),
    .need_i    (need_q),
    .din_i     (sync_lvl),
    .filt_o    (filt_lvl)
  );

  assign fault_active = (filt_lvl == pol_q);

  ffilt_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (fault_active),
    .clr_i    (flag_clr),
    .ie_i     (ie_q),
    .flag_o   (flag),
    .irq_o    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel_e'(reg_addr) == REG_CFG) begin
      reg_rdata[PER_LSB +: PER_W] = period_q;
      reg_rdata[CNT_LSB +: CNT_W] = need_q;
      reg_rdata[POL_BIT]          = pol_q;
      reg_rdata[IE_BIT]           = ie_q;
    end else begin
      reg_rdata[STAT_PIN_BIT]  = fault_active;
      reg_rdata[STAT_FLAG_BIT] = flag;
    end
  end

  // R10
  irq_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reg_sel_e'(reg_addr) == REG_CFG || reg_rdata[STAT_FLAG_BIT]);
endmodule

// File: tb/test_fault_glitch_filter.sv
module test_fault_glitch_filter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fault_in = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic       fault_active;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_glitch_filter i_fault_glitch_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_in     (fault_in),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .fault_active (fault_active),
    .irq          (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [8:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  function automatic logic [8:0] cfgw(input int per, input int cnt, input int pol, input int ie);
    return {ie[0], pol[0], cnt[2:0], per[3:0]};
  endfunction

  task automatic pulse(input int per, input int cnt, input int len, output int flag);
    int v;
    wr(1'b0, cfgw(per, cnt, 0, 0));
    step(40);
    wr(1'b1, 9'h002);
    fault_in = 1'b0;
    step(len);
    fault_in = 1'b1;
    step(40);
    rd(1'b1, v);
    flag = (v >> 1) & 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int fl;
    step(3);
    rst_n = 1'b1;
    step(2);

    // R7 / R11 reset state
    check("R7 fault_active at reset", fault_active, 0);
    check("R7 irq at reset", irq, 0);
    rd(1'b1, v); check("R11 status after reset", v, 0);
    rd(1'b0, v); check("R11 config after reset", v, 0);

    // R1 / R5 bypass latency
    fault_in = 1'b0;
    step(1); check("R1 after edge 1", fault_active, 0);
    step(1); check("R1 after edge 2", fault_active, 0);
    step(1); check("R1 R5 after edge 3", fault_active, 1);
    step(1);
    rd(1'b1, v); check("R8 R11 flag and status set", v, 3);
    check("R10 irq with enable off", irq, 0);

    wr(1'b0, cfgw(0, 0, 0, 1));
    check("R10 irq after enable", irq, 1);
    rd(1'b0, v); check("R11 config readback", v, 9'h100);

    // R9 clear during active fault
    wr(1'b1, 9'h002);
    rd(1'b1, v); check("R9 flag kept by active fault", (v >> 1) & 1, 1);
    check("R9 irq kept", irq, 1);

    // R7 / R8 release and sticky
    fault_in = 1'b1;
    step(3); check("R7 status cleared on release", fault_active, 0);
    step(2);
    rd(1'b1, v); check("R8 flag sticky after release", v, 2);
    wr(1'b1, 9'h002);
    rd(1'b1, v); check("R8 flag cleared by write one", v, 0);
    check("R10 irq dropped on clear", irq, 0);

    // R10 enable-off release
    fault_in = 1'b0; step(5); fault_in = 1'b1; step(5);
    check("R10 irq set again", irq, 1);
    wr(1'b0, cfgw(0, 0, 0, 0));
    check("R10 irq dropped by enable off", irq, 0);
    rd(1'b1, v); check("R10 flag kept when enable off", v, 2);
    wr(1'b1, 9'h002);

    // R6 polarity
    fault_in = 1'b0;
    wr(1'b0, cfgw(0, 0, 1, 0));
    step(5);
    wr(1'b1, 9'h002);
    rd(1'b1, v); check("R6 low is not a fault with polarity 1", v, 0);
    fault_in = 1'b1; step(3);
    check("R6 high is a fault with polarity 1", fault_active, 1);
    fault_in = 1'b0; step(3);
    check("R6 low releases with polarity 1", fault_active, 0);
    fault_in = 1'b1;
    wr(1'b0, cfgw(0, 0, 0, 0));
    step(5);
    wr(1'b1, 9'h002);
    rd(1'b1, v); check("R6 back to polarity 0 idle", v, 0);

    // R2 R3 R4 sweep of period and count
    for (int per = 1; per <= 3; per++) begin
      for (int cnt = 0; cnt <= 4; cnt++) begin
        int neff;
        neff = (cnt == 0) ? 1 : cnt;
        pulse(per, cnt, neff * per, fl);
        if (cnt == 0) check("R4 count zero accepts one period", fl, 1);
        else          check("R2 R3 pulse of N*P accepted", fl, 1);
        check("R7 idle after pulse", fault_active, 0);
        if (neff >= 2) begin
          pulse(per, cnt, (neff - 1) * per, fl);
          check("R2 R3 pulse of (N-1)*P rejected", fl, 0);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule